// File: doc/BRIEF.md
# Accumulator Saturating Extract Unit

This unit turns a wide multiply-accumulate result into a 32-bit register value. It joins two 32-bit halves into one signed 64-bit accumulator. A selector code then picks one of five clamp windows, and the clamped value is returned as a 32-bit word. Every extract also reports the sticky accumulator overflow as the status V flag and clears the status C flag.

A second mode ignores the accumulator and the selector. It saturates an ordinary 32-bit register operand to the signed 16-bit range and reports negative and zero flags for the result.

All range tests are combinational and the outputs pass through one register stage. A request presented on one rising edge therefore shows its result after that edge. The result word and the flag values hold between writes. Each write strobe is high for exactly one cycle per accepted request.

Top module: `acc_sat_extract`

## Requirements
- R1: In extract mode (mode_i = 0) with selector 0x00000020, the signed accumulator {acc_hi_i, acc_lo_i} gives 0x7FFFFFFF when it is above 2^31-1 and 0x80000000 when it is below -2^31. Any other accumulator value gives its low 32 bits. res_valid_o is raised.
- R2: Selector 0x00000010 gives 0x00007FFF above 32767 and 0x00008000 (not sign extended) below -32768. Otherwise it gives the low 32 bits, so -32768 itself gives 0xFFFF8000.
- R3: Selector 0x00000008 gives 0x0000007F above 127 and 0x00000080 below -128. Otherwise it gives the low 32 bits.
- R4: Selector 0x00000009 gives 0x00000080 above 128 and 0x00000081 below -127. Otherwise it gives the low 32 bits, so 128 gives 0x80 and -127 gives 0xFFFFFF81.
- R5: Selector 0x00000030 clamps the accumulator to [-2^47, 2^47-1], shifts it arithmetically right by 16, and gives the low 32 bits of the shifted value.
- R6: Every extract request, whatever its selector, raises vc_we_o for one cycle with v_o equal to acc_ovf_i. A raised vc_we_o means V is written from v_o and C is cleared.
- R7: An extract with a selector other than the five listed raises no res_valid_o and leaves res_o unchanged.
- R8: In saturate mode (mode_i = 1), a signed src_i of 32767 or more gives 0x00007FFF and one of -32768 or less gives 0xFFFF8000. Any other value passes unchanged. res_valid_o is raised.
- R9: Saturate mode raises nz_we_o, with n_o equal to bit 15 of the result and z_o set when the result is zero. It does not raise vc_we_o. Extract mode never raises nz_we_o.
- R10: The outputs appear one rising edge after the request. With in_valid_i low, no strobe is raised on the next edge. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid_i | input | 1 | Request present this cycle |
| mode_i | input | 1 | 0 = accumulator extract, 1 = 16-bit register saturate |
| sel_i | input | 32 | Clamp selector code (extract mode) |
| acc_hi_i | input | 32 | Upper half of the accumulator |
| acc_lo_i | input | 32 | Lower half of the accumulator |
| acc_ovf_i | input | 1 | Sticky accumulator overflow |
| src_i | input | 32 | Register operand (saturate mode) |
| res_valid_o | output | 1 | Destination write strobe |
| res_o | output | 32 | Result word |
| vc_we_o | output | 1 | Write V from v_o and clear C |
| v_o | output | 1 | New V value |
| nz_we_o | output | 1 | Write N and Z |
| n_o | output | 1 | New N value |
| z_o | output | 1 | New Z value |

## Verification
Each selector is tried with accumulators just above the upper bound, just below the lower bound, exactly on a bound, and well inside the window. Together these separate strict from inclusive comparisons and catch off-by-one limits, such as the asymmetric 9-bit pair. They also separate truncated outputs from sign-extended ones, which is where the 8-bit and 16-bit minimum codes differ from pass-through values. The 48-bit selector uses values with nonzero bits above bit 47 and negative in-range values, which shows whether the shift is arithmetic. Saturate mode is driven with values on both sides of each threshold and with 0x80000000, which exposes an unsigned comparison. Unsupported codes are interleaved with valid ones so that a stale or overwritten result word is visible.

// File: rtl/acc_sat_pkg.sv
package acc_sat_pkg;

    localparam int DATA_W    = 32;
    localparam int ACC_W     = 2 * DATA_W;
    localparam int NUM_LANES = 5;
    localparam int SHIFT_W   = 5;
    localparam int SAT_W     = 16;

    typedef enum logic {
        MODE_ACC_EXTRACT = 1'b0,
        MODE_REG_SAT16   = 1'b1
    } op_mode_e;

    typedef struct packed {
        logic [DATA_W-1:0]  code;
        logic [ACC_W-1:0]   hi_lim;
        logic [ACC_W-1:0]   lo_lim;
        logic [DATA_W-1:0]  out_hi;
        logic [DATA_W-1:0]  out_lo;
        logic [SHIFT_W-1:0] shift;
    } lane_spec_t;

    typedef struct packed {
        logic              res_valid;
        logic [DATA_W-1:0] res;
        logic              vc_we;
        logic              v;
        logic              nz_we;
        logic              n;
        logic              z;
    } out_state_t;

    function automatic lane_spec_t lane_spec(input int idx);
        lane_spec_t s;
        case (idx)
            0: s = '{32'h0000_0020, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_8000_0000,
                     32'h7FFF_FFFF, 32'h8000_0000, 5'd0};
            1: s = '{32'h0000_0010, 64'h0000_0000_0000_7FFF, 64'hFFFF_FFFF_FFFF_8000,
                     32'h0000_7FFF, 32'h0000_8000, 5'd0};
            2: s = '{32'h0000_0008, 64'h0000_0000_0000_007F, 64'hFFFF_FFFF_FFFF_FF80,
                     32'h0000_007F, 32'h0000_0080, 5'd0};
            3: s = '{32'h0000_0009, 64'h0000_0000_0000_0080, 64'hFFFF_FFFF_FFFF_FF81,
                     32'h0000_0080, 32'h0000_0081, 5'd0};
            default: s = '{32'h0000_0030, 64'h0000_7FFF_FFFF_FFFF, 64'hFFFF_8000_0000_0000,
                     32'h7FFF_FFFF, 32'h8000_0000, 5'd16};
        endcase
        return s;
    endfunction

endpackage

// File: rtl/acc_clamp.sv
module acc_clamp
    import acc_sat_pkg::*;
#(
    parameter int D_W   = DATA_W,
    parameter int A_W   = ACC_W,
    parameter int LANES = NUM_LANES
) (
    input  logic [A_W-1:0] acc_i,
    input  logic [D_W-1:0] sel_i,
    output logic           hit_o,
    output logic [D_W-1:0] res_o
);

    logic [LANES-1:0]          hit_v;
    logic [LANES-1:0][D_W-1:0] val_v;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam lane_spec_t SP = lane_spec(i);
        logic [D_W-1:0] lane_val;

        always_comb begin
            if ($signed(acc_i) > $signed(SP.hi_lim)) begin
                lane_val = SP.out_hi;
            end else if ($signed(acc_i) < $signed(SP.lo_lim)) begin
                lane_val = SP.out_lo;
            end else begin
                lane_val = D_W'($signed(acc_i) >>> SP.shift);
            end
        end

        assign hit_v[i] = (sel_i == SP.code);
        assign val_v[i] = lane_val;
    end

    always_comb begin
        hit_o = 1'b0;
        res_o = '0;
        for (int k = 0; k < LANES; k++) begin
            if (hit_v[k]) begin
                hit_o = 1'b1;
                res_o = val_v[k];
            end
        end
    end

endmodule

// File: rtl/reg_sat16.sv
module reg_sat16
    import acc_sat_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int S_W = SAT_W
) (
    input  logic [D_W-1:0] src_i,
    output logic [D_W-1:0] res_o
);

    localparam logic [D_W-1:0] MAX_V = D_W'((64'd1 << (S_W - 1)) - 64'd1);
    localparam logic [D_W-1:0] MIN_V = ~MAX_V;

    always_comb begin
        if ($signed(src_i) >= $signed(MAX_V)) begin
            res_o = MAX_V;
        end else if ($signed(src_i) <= $signed(MIN_V)) begin
            res_o = MIN_V;
        end else begin
            res_o = src_i;
        end
    end

endmodule

// File: rtl/acc_sat_extract.sv
module acc_sat_extract
    import acc_sat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] sel_i,
    input  logic [DATA_W-1:0] acc_hi_i,
    input  logic [DATA_W-1:0] acc_lo_i,
    input  logic              acc_ovf_i,
    input  logic [DATA_W-1:0] src_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_o,
    output logic              vc_we_o,
    output logic              v_o,
    output logic              nz_we_o,
    output logic              n_o,
    output logic              z_o
);

    logic              clamp_hit;
    logic [DATA_W-1:0] clamp_res;
    logic [DATA_W-1:0] sat_res;
    op_mode_e          mode;
    out_state_t        st_d, st_q;

    assign mode = op_mode_e'(mode_i);

    acc_clamp u_clamp (
        .acc_i ({acc_hi_i, acc_lo_i}),
        .sel_i (sel_i),
        .hit_o (clamp_hit),
        .res_o (clamp_res)
    );

    reg_sat16 u_sat (
        .src_i (src_i),
        .res_o (sat_res)
    );

    always_comb begin
        st_d           = st_q;
        st_d.res_valid = 1'b0;
        st_d.vc_we     = 1'b0;
        st_d.nz_we     = 1'b0;
        if (in_valid_i) begin
            if (mode == MODE_ACC_EXTRACT) begin
                st_d.vc_we = 1'b1;
                st_d.v     = acc_ovf_i;
                if (clamp_hit) begin
                    st_d.res_valid = 1'b1;
                    st_d.res       = clamp_res;
                end
            end else begin
                st_d.res_valid = 1'b1;
                st_d.res       = sat_res;
                st_d.nz_we     = 1'b1;
                st_d.n         = sat_res[SAT_W-1];
                st_d.z         = (sat_res == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.res_valid;
    assign res_o       = st_q.res;
    assign vc_we_o     = st_q.vc_we;
    assign v_o         = st_q.v;
    assign nz_we_o     = st_q.nz_we;
    assign n_o         = st_q.n;
    assign z_o         = st_q.z;

    // R6
    v_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !mode_i) |=> (vc_we_o && !nz_we_o && (v_o == $past(acc_ovf_i))));

    // R9
    sat_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && mode_i) |=> (nz_we_o && res_valid_o && !vc_we_o));

    // R8
    sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && nz_we_o) |-> (($signed(res_o) <= 32767) && ($signed(res_o) >= -32768)));

    // R7
    unsup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !mode_i && !clamp_hit) |=> (!res_valid_o && $stable(res_o)));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i |=> (!res_valid_o && !vc_we_o && !nz_we_o));

    // R1
    in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && !mode_i && (sel_i == 32'h20) && (acc_hi_i == {DATA_W{acc_lo_i[DATA_W-1]}}))
        |=> (res_o == $past(acc_lo_i)));

endmodule

// File: tb/acc_sat_extract_tb.sv
module acc_sat_extract_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] sel_i = '0;
    logic [31:0] acc_hi_i = '0;
    logic [31:0] acc_lo_i = '0;
    logic        acc_ovf_i = 1'b0;
    logic [31:0] src_i = '0;
    logic        res_valid_o, vc_we_o, v_o, nz_we_o, n_o, z_o;
    logic [31:0] res_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    acc_sat_extract u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid_i), .mode_i(mode_i),
        .sel_i(sel_i), .acc_hi_i(acc_hi_i), .acc_lo_i(acc_lo_i), .acc_ovf_i(acc_ovf_i),
        .src_i(src_i), .res_valid_o(res_valid_o), .res_o(res_o), .vc_we_o(vc_we_o),
        .v_o(v_o), .nz_we_o(nz_we_o), .n_o(n_o), .z_o(z_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, result registered on the rising edge, sample at the next falling edge
    task automatic op(input logic m, input logic [31:0] sel, input logic [31:0] hi,
                      input logic [31:0] lo, input logic ovf, input logic [31:0] src);
        @(negedge clk);
        in_valid_i = 1'b1; mode_i = m; sel_i = sel;
        acc_hi_i = hi; acc_lo_i = lo; acc_ovf_i = ovf; src_i = src;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic ext(input string tag, input logic [31:0] sel, input logic [31:0] hi,
                       input logic [31:0] lo, input logic [31:0] exp);
        op(1'b0, sel, hi, lo, 1'b0, 32'hDEAD_BEEF);
        chk({tag, " res"}, res_o, exp);
        chk({tag, " valid"}, {31'd0, res_valid_o}, 32'd1);
        chk({tag, " R9 no nz"}, {31'd0, nz_we_o}, 32'd0);
    endtask

    task automatic t_reset();
        chk("R10 reset res", res_o, 32'd0);
        chk("R10 reset strobes", {29'd0, res_valid_o, vc_we_o, nz_we_o}, 32'd0);
    endtask

    task automatic t_sel32();
        ext("R1 inside", 32'h20, 32'h0, 32'h5, 32'h5);
        ext("R1 above", 32'h20, 32'h1, 32'h0, 32'h7FFF_FFFF);
        ext("R1 minus one", 32'h20, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        ext("R1 below", 32'h20, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000);
        ext("R1 on min", 32'h20, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000);
        ext("R1 far above", 32'h20, 32'h0, 32'h8000_0000, 32'h7FFF_FFFF);
    endtask

    task automatic t_sel16();
        ext("R2 above", 32'h10, 32'h0, 32'h8000, 32'h7FFF);
        ext("R2 below", 32'h10, 32'hFFFF_FFFF, 32'hFFFF_7FFF, 32'h0000_8000);
        ext("R2 on min", 32'h10, 32'hFFFF_FFFF, 32'hFFFF_8000, 32'hFFFF_8000);
        ext("R2 inside", 32'h10, 32'h0, 32'h1234, 32'h1234);
    endtask

    task automatic t_sel8();
        ext("R3 above", 32'h08, 32'h0, 32'h80, 32'h7F);
        ext("R3 below", 32'h08, 32'hFFFF_FFFF, 32'hFFFF_FF7F, 32'h80);
        ext("R3 on min", 32'h08, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'hFFFF_FF80);
        ext("R3 on max", 32'h08, 32'h0, 32'h7F, 32'h7F);
    endtask

    task automatic t_sel9();
        ext("R4 above", 32'h09, 32'h0, 32'h81, 32'h80);
        ext("R4 on max", 32'h09, 32'h0, 32'h80, 32'h80);
        ext("R4 below", 32'h09, 32'hFFFF_FFFF, 32'hFFFF_FF80, 32'h81);
        ext("R4 on min", 32'h09, 32'hFFFF_FFFF, 32'hFFFF_FF81, 32'hFFFF_FF81);
    endtask

    task automatic t_sel48();
        ext("R5 inside", 32'h30, 32'h0000_1234, 32'h5678_9ABC, 32'h1234_5678);
        ext("R5 above", 32'h30, 32'h0001_0000, 32'h0, 32'h7FFF_FFFF);
        ext("R5 below", 32'h30, 32'hFFFF_0000, 32'h0, 32'h8000_0000);
        ext("R5 neg inside", 32'h30, 32'hFFFF_FFFF, 32'hFFFF_0000, 32'hFFFF_FFFF);
    endtask

    task automatic t_flags();
        op(1'b0, 32'h20, 32'h0, 32'h1, 1'b1, 32'h0);
        chk("R6 v set", {30'd0, vc_we_o, v_o}, 32'd3);
        op(1'b0, 32'h08, 32'h0, 32'h1, 1'b0, 32'h0);
        chk("R6 v clear", {30'd0, vc_we_o, v_o}, 32'd2);
        op(1'b0, 32'h55, 32'h0, 32'h1, 1'b1, 32'h0);
        chk("R6 v on unsupported", {30'd0, vc_we_o, v_o}, 32'd3);
    endtask

    task automatic t_unsup();
        ext("R7 prime", 32'h10, 32'h0, 32'h0000_0321, 32'h0000_0321);
        op(1'b0, 32'h11, 32'h7, 32'h0, 1'b0, 32'h0);
        chk("R7 no valid", {31'd0, res_valid_o}, 32'd0);
        chk("R7 held", res_o, 32'h0000_0321);
        op(1'b0, 32'h0, 32'h0, 32'h9, 1'b0, 32'h0);
        chk("R7 zero code held", res_o, 32'h0000_0321);
    endtask

    task automatic sat(input string tag, input logic [31:0] src, input logic [31:0] exp,
                       input logic n_exp, input logic z_exp);
        op(1'b1, 32'h20, 32'h1, 32'h0, 1'b1, src);
        chk({tag, " R8 res"}, res_o, exp);
        chk({tag, " R9 nz"}, {29'd0, nz_we_o, n_o, z_o}, {29'd0, 1'b1, n_exp, z_exp});
        chk({tag, " R9 no vc"}, {30'd0, vc_we_o, res_valid_o}, 32'd1);
    endtask

    task automatic t_sat16();
        sat("max", 32'h0000_7FFF, 32'h0000_7FFF, 1'b0, 1'b0);
        sat("big", 32'h0001_2345, 32'h0000_7FFF, 1'b0, 1'b0);
        sat("below max", 32'h0000_7FFE, 32'h0000_7FFE, 1'b0, 1'b0);
        sat("min", 32'hFFFF_8000, 32'hFFFF_8000, 1'b1, 1'b0);
        sat("most neg", 32'h8000_0000, 32'hFFFF_8000, 1'b1, 1'b0);
        sat("above min", 32'hFFFF_8001, 32'hFFFF_8001, 1'b1, 1'b0);
        sat("zero", 32'h0, 32'h0, 1'b0, 1'b1);
        sat("small neg", 32'hFFFF_FFFE, 32'hFFFF_FFFE, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        ext("R10 prime", 32'h20, 32'h0, 32'h42, 32'h42);
        @(negedge clk);
        chk("R10 idle strobes", {29'd0, res_valid_o, vc_we_o, nz_we_o}, 32'd0);
        chk("R10 idle hold", res_o, 32'h42);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL R10 watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_sel32();
        t_sel16();
        t_sel8();
        t_sel9();
        t_sel48();
        t_flags();
        t_unsup();
        t_sat16();
        t_idle();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule